// File: doc/BRIEF.md
# Multi-Sensor Bit-Serial Thermometer Interface

This block is a register-mapped front end for a group of digital temperature sensors that are driven in lockstep over a bit-serial protocol. A host writes codes to three registers. The first is a control register, which resets the transfer and raises or lowers a serial clock-low flag. The second is a data-write register, which takes one command bit per write. The third is a data-read register, which returns one bit from every sensor at once. In that returned word, sensor i is placed in bit i.

Each sensor is modelled by a constant configuration register and a constant temperature register. The block does the following:
- It shifts in an 8-bit command, least significant bit first.
- It decodes the start-conversion, read-config and read-temperature commands.
- It walks a shared bit position through the selected register on every read.
- It clears the transfer by itself once the last bit of a read has been returned.

Analog sensing and conversion timing are not modelled.

Top module: `thermo_serial_if`

## Requirements
- R1: After reset, the read data is 0. A data-read access returns 0 while no read command is held.
- R2: The control register works through the flag as follows. Code 0x10 sets the clock-low flag and code 0x11 clears it. A write to the data-write register, other than the enable-read code, has no effect while the flag is clear.
- R3: Command bits are taken least significant bit first, and the command is 8 bits wide. The code 0x01 stores a one at the current command bit. Any other code stores a zero there.
- R4: A completed command of 0xEE (start conversion) clears the transfer state at once. The next read returns 0, and the next 8 bit writes load a new command.
- R5: When command 0xAA (read temperature) is held, read n (n = 0..8) returns bit n of every sensor's temperature register. That register resets to 44, which is 22 degrees in half-degree steps. After the ninth read the transfer is cleared.
- R6: When command 0xAC (read config) is held, read n (n = 0..7) returns bit n of every sensor's config register. That register resets to 0x02, with the CPU-mode bit 1 set. After the eighth read the transfer is cleared.
- R7: Control code 0xA5 clears the command word, the command bit count and the bit position. It leaves the clock-low flag unchanged.
- R8: The code 0x80, written to the data-write register, resets only the bit position. It does so whatever the state of the clock-low flag.
- R9: Once a full command is held, each further gated data write advances the bit position by one.
- R10: When any other command value is held, reads return 0 and leave the bit position unchanged.
- R11: The read data is registered. It takes a new value one cycle after a read strobe and holds in every other cycle. A read of any address other than 2 returns 0 and changes no state. A write and a read strobed in the same cycle perform the write only. The register addresses are: control 0, data-write 1, data-read 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 2 | Register address (0 control, 1 data-write, 2 data-read) |
| bus_wdata | input | 8 | Write data / code |
| bus_rdata | output | 8 | Registered read data, sensor i in bit i |

## Verification
The assertions check the following on every cycle:
- the command bit count never passes the command width;
- the control reset always empties the transfer;
- the enable-read code always zeroes the position;
- a gated-off write leaves the transfer untouched;
- each read of a held command steps or ends the transfer correctly;
- the read data holds outside read strobes.

Only the bench scenarios can show the following:
- the least-significant-bit-first order of the command bits;
- which bit of which register each read returns;
- the interplay between data-phase writes and later reads;
- that the flag survives a control reset.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
   localparam int CODE_W = 8;

   localparam logic [1:0] ADDR_CTRL  = 2'd0;
   localparam logic [1:0] ADDR_WBIT  = 2'd1;
   localparam logic [1:0] ADDR_RBITS = 2'd2;

   localparam logic [CODE_W-1:0] CTL_CLEAR   = 8'hA5;
   localparam logic [CODE_W-1:0] CTL_SCK_LO  = 8'h10;
   localparam logic [CODE_W-1:0] CTL_SCK_HI  = 8'h11;

   localparam logic [CODE_W-1:0] WB_ONE      = 8'h01;
   localparam logic [CODE_W-1:0] WB_RD_ARM   = 8'h80;

   localparam logic [CODE_W-1:0] OP_CONVERT  = 8'hEE;
   localparam logic [CODE_W-1:0] OP_GET_CFG  = 8'hAC;
   localparam logic [CODE_W-1:0] OP_GET_TEMP = 8'hAA;
endpackage

// File: rtl/thermo_sensor_bank.sv
module thermo_sensor_bank #(
   parameter int          NUM_SENSORS = 4,
   parameter int          CFG_W       = 8,
   parameter int          TEMP_W      = 9,
   parameter int          POS_W       = 5,
   parameter logic [CFG_W-1:0]  CFG_INIT  = 8'h02,
   parameter logic [TEMP_W-1:0] TEMP_INIT = 9'd44
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [POS_W-1:0]       bit_pos,
   output logic [NUM_SENSORS-1:0] cfg_slice,
   output logic [NUM_SENSORS-1:0] temp_slice
);
   for (genvar s = 0; s < NUM_SENSORS; s++) begin : g_sensor
      logic [CFG_W-1:0]  cfg_q;
      logic [TEMP_W-1:0] temp_q;
      logic [CFG_W-1:0]  cfg_sh;
      logic [TEMP_W-1:0] temp_sh;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cfg_q  <= CFG_INIT;
            temp_q <= TEMP_INIT;
         end else begin
            cfg_q  <= cfg_q;
            temp_q <= temp_q;
         end
      end

      always_comb begin
         cfg_sh  = cfg_q >> bit_pos;
         temp_sh = temp_q >> bit_pos;
      end

      assign cfg_slice[s]  = cfg_sh[0];
      assign temp_slice[s] = temp_sh[0];
   end
endmodule

// File: rtl/thermo_xfer_ctrl.sv
module thermo_xfer_ctrl
   import thermo_pkg::*;
#(
   parameter int CFG_LEN  = 8,
   parameter int TEMP_LEN = 9,
   parameter int POS_W    = 5,
   localparam int CMD_W   = CODE_W,
   localparam int CPOS_W  = $clog2(CMD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic              bit_we,
   input  logic              bits_re,
   input  logic [CODE_W-1:0] wcode,
   output logic [POS_W-1:0]  bit_pos,
   output logic              pick_cfg,
   output logic              pick_temp
);
   logic [CMD_W-1:0]  cmd_q;
   logic [CPOS_W-1:0] cmd_cnt_q;
   logic [POS_W-1:0]  pos_q;
   logic              sck_lo_q;
   logic [CMD_W-1:0]  cmd_next;
   logic              cmd_last;
   logic              rd_last;

   always_comb begin
      cmd_next = cmd_q | (CMD_W'(wcode == WB_ONE) << cmd_cnt_q);
      cmd_last = (cmd_cnt_q == CPOS_W'(CMD_W - 1));
      pick_cfg  = (cmd_q == OP_GET_CFG);
      pick_temp = (cmd_q == OP_GET_TEMP);
      rd_last = (pick_cfg  && pos_q == POS_W'(CFG_LEN - 1)) ||
                (pick_temp && pos_q == POS_W'(TEMP_LEN - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q     <= '0;
         cmd_cnt_q <= '0;
         pos_q     <= '0;
         sck_lo_q  <= 1'b0;
      end else if (ctl_we) begin
         case (wcode)
            CTL_CLEAR: begin
               cmd_q     <= '0;
               cmd_cnt_q <= '0;
               pos_q     <= '0;
            end
            CTL_SCK_LO: sck_lo_q <= 1'b1;
            CTL_SCK_HI: sck_lo_q <= 1'b0;
            default: ;
         endcase
      end else if (bit_we) begin
         if (wcode == WB_RD_ARM) begin
            pos_q <= '0;
         end else if (sck_lo_q) begin
            if (cmd_cnt_q < CPOS_W'(CMD_W)) begin
               if (cmd_last && cmd_next == OP_CONVERT) begin
                  cmd_q     <= '0;
                  cmd_cnt_q <= '0;
                  pos_q     <= '0;
               end else begin
                  cmd_q     <= cmd_next;
                  cmd_cnt_q <= cmd_cnt_q + 1'b1;
               end
            end else begin
               pos_q <= pos_q + 1'b1;
            end
         end
      end else if (bits_re && (pick_cfg || pick_temp)) begin
         if (rd_last) begin
            cmd_q     <= '0;
            cmd_cnt_q <= '0;
            pos_q     <= '0;
         end else begin
            pos_q <= pos_q + 1'b1;
         end
      end
   end

   assign bit_pos = pos_q;

   // R3
   cmd_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_cnt_q <= CPOS_W'(CMD_W));

   // R7
   ctl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && wcode == CTL_CLEAR) |=> (cmd_q == '0 && cmd_cnt_q == '0 && pos_q == '0));

   // R8
   rd_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && bit_we && wcode == WB_RD_ARM) |=> (pos_q == '0));

   // R2
   gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && bit_we && !sck_lo_q && wcode != WB_RD_ARM)
      |=> ($stable(cmd_q) && $stable(cmd_cnt_q) && $stable(pos_q)));

   // R5
   rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && !bit_we && bits_re && (pick_cfg || pick_temp) && !rd_last)
      |=> (pos_q == $past(pos_q) + 1'b1));

   // R6
   rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && !bit_we && bits_re && rd_last) |=> (cmd_q == '0 && pos_q == '0));

   // R10
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && !bit_we && bits_re && !pick_cfg && !pick_temp) |=> $stable(pos_q));
endmodule

// File: rtl/thermo_serial_if.sv
module thermo_serial_if
   import thermo_pkg::*;
#(
   parameter int NUM_SENSORS = 4,
   parameter int CFG_LEN     = 8,
   parameter int TEMP_LEN    = 9,
   parameter int CFG_INIT    = 2,
   parameter int TEMP_INIT   = 44,
   localparam int MAX_LEN    = (TEMP_LEN > CFG_LEN) ? TEMP_LEN : CFG_LEN,
   localparam int POS_W      = $clog2(MAX_LEN) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [CODE_W-1:0] bus_wdata,
   output logic [CODE_W-1:0] bus_rdata
);
   if (NUM_SENSORS < 1 || NUM_SENSORS > CODE_W) begin : g_bad_count
      $error("NUM_SENSORS must lie in 1..CODE_W");
   end
   if (CFG_LEN < 2 || TEMP_LEN < 2) begin : g_bad_len
      $error("read lengths must be at least 2");
   end

   logic                   ctl_we, bit_we, bits_re, rd_go;
   logic [POS_W-1:0]       bit_pos;
   logic                   pick_cfg, pick_temp;
   logic [NUM_SENSORS-1:0] cfg_slice, temp_slice, slice;
   logic [CODE_W-1:0]      rdata_q;

   always_comb begin
      ctl_we  = bus_wr && (bus_addr == ADDR_CTRL);
      bit_we  = bus_wr && (bus_addr == ADDR_WBIT);
      rd_go   = bus_rd && !bus_wr;
      bits_re = rd_go && (bus_addr == ADDR_RBITS);
      slice   = pick_cfg ? cfg_slice : (pick_temp ? temp_slice : '0);
   end

   thermo_xfer_ctrl #(
      .CFG_LEN  (CFG_LEN),
      .TEMP_LEN (TEMP_LEN),
      .POS_W    (POS_W)
   ) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we),
      .bit_we    (bit_we),
      .bits_re   (bits_re),
      .wcode     (bus_wdata),
      .bit_pos   (bit_pos),
      .pick_cfg  (pick_cfg),
      .pick_temp (pick_temp)
   );

   thermo_sensor_bank #(
      .NUM_SENSORS (NUM_SENSORS),
      .CFG_W       (CFG_LEN),
      .TEMP_W      (TEMP_LEN),
      .POS_W       (POS_W),
      .CFG_INIT    (CFG_LEN'(CFG_INIT)),
      .TEMP_INIT   (TEMP_LEN'(TEMP_INIT))
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_pos    (bit_pos),
      .cfg_slice  (cfg_slice),
      .temp_slice (temp_slice)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rdata_q <= '0;
      else if (rd_go) rdata_q <= bits_re ? CODE_W'(slice) : '0;
   end

   assign bus_rdata = rdata_q;

   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_go |=> $stable(bus_rdata));

   // R11
   other_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && bus_addr != ADDR_RBITS) |=> (bus_rdata == '0));
endmodule

// File: tb/thermo_serial_if_bench.sv
module thermo_serial_if_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   thermo_serial_if u_thermo_serial_if (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   function automatic logic [7:0] temp_exp(int n);
      return ((44 >> n) & 1) != 0 ? 8'h0F : 8'h00;
   endfunction
   function automatic logic [7:0] cfg_exp(int n);
      return ((2 >> n) & 1) != 0 ? 8'h0F : 8'h00;
   endfunction

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd_at(input logic [1:0] a, input logic [7:0] exp, input string req);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      @(negedge clk); bus_rd = 1'b0;
      check(bus_rdata, exp, req);
   endtask

   task automatic rd(input logic [7:0] exp, input string req);
      rd_at(2'd2, exp, req);
   endtask

   task automatic send_cmd(input logic [7:0] c, input logic [7:0] zero_code);
      for (int i = 0; i < 8; i++) wr(2'd1, c[i] ? 8'h01 : zero_code);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state and idle read
      check(bus_rdata, 8'h00, "R1");
      rd(8'h00, "R1");
      rd_at(2'd0, 8'h00, "R11");

      // R2: flag clear, command ignored
      wr(2'd0, 8'h11);
      send_cmd(8'hAA, 8'h00);
      rd(8'h00, "R2");
      wr(2'd0, 8'h10);
      send_cmd(8'hAA, 8'h00);
      // R5: full temperature sweep, then cleared
      for (int n = 0; n < 9; n++) rd(temp_exp(n), "R5");
      rd(8'h00, "R5");

      // R6: config sweep
      send_cmd(8'hAC, 8'h00);
      for (int n = 0; n < 8; n++) rd(cfg_exp(n), "R6");
      rd(8'h00, "R6");

      // R3: bit-reversed command is unknown; non-one codes count as zero
      send_cmd(8'h55, 8'h00);
      rd(8'h00, "R3");
      wr(2'd0, 8'hA5);
      send_cmd(8'hAA, 8'h7E);
      rd(temp_exp(0), "R3");
      rd(temp_exp(1), "R3");
      wr(2'd0, 8'hA5);

      // R4: start conversion clears, next command loads at once
      send_cmd(8'hEE, 8'h00);
      rd(8'h00, "R4");
      send_cmd(8'hAA, 8'h00);
      rd(temp_exp(0), "R4");

      // R7: clear mid-read, flag survives
      rd(temp_exp(1), "R7");
      rd(temp_exp(2), "R7");
      wr(2'd0, 8'hA5);
      rd(8'h00, "R7");
      send_cmd(8'hAA, 8'h00);
      rd(temp_exp(0), "R7");

      // R8: rearm with flag clear
      rd(temp_exp(1), "R8");
      rd(temp_exp(2), "R8");
      wr(2'd0, 8'h11);
      wr(2'd1, 8'h80);
      for (int n = 0; n < 9; n++) rd(temp_exp(n), "R8");
      rd(8'h00, "R8");

      // R9: data-phase writes advance the position
      wr(2'd0, 8'h10);
      send_cmd(8'hAA, 8'h00);
      for (int k = 0; k < 3; k++) wr(2'd1, 8'h01);
      for (int n = 3; n < 9; n++) rd(temp_exp(n), "R9");
      rd(8'h00, "R9");

      // R10: unknown command holds position
      send_cmd(8'h00, 8'h00);
      rd(8'h00, "R10");
      rd(8'h00, "R10");
      wr(2'd0, 8'hA5);
      send_cmd(8'hAC, 8'h00);
      rd(cfg_exp(0), "R10");
      rd(cfg_exp(1), "R10");

      // R11: write and read together performs only the write; addr 3 reads zero
      @(negedge clk); bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h33;
      @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
      check(bus_rdata, cfg_exp(1), "R11");
      rd_at(2'd3, 8'h00, "R11");
      rd(cfg_exp(2), "R11");

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule